// File: doc/BRIEF.md
# Paired Stereo Transmit Sample Buffer

This block sits between a processor and the serializer of a stereo digital audio transmitter. It holds left-channel samples in one FIFO and right-channel samples in another. The processor fills them through two independent write streams. A consumer on the serializer side pulls samples one at a time, always left then right, so each pair of requests makes one frame.

When only one channel runs dry, a plain pair of FIFOs would drift by one sample and swap or mispair the channels from then on. This block prevents that. A read that finds one side empty returns a zero sample for that side. It also marks the next read of the opposite side to be suppressed, so that side keeps its head sample. The suppressed read also returns zero and is reported as a resynchronisation.

Status is reported on plain pins. `buf_empty` is a live level that is high only while both channels are empty. `flag_xrun` is a sticky flag for an overrun or underrun on either side. `flag_resync` is a sticky flag for a suppressed read. Each sticky flag is cleared by a one-cycle pulse on its own write-one-to-clear pin.

Write streams use valid/ready. `*_ready` is low exactly while that channel holds DEPTH samples. A transfer is a cycle with `*_valid` high and `*_ready` high. A beat offered while `*_ready` is low is dropped; the producer is expected to wait on ready. The sample output has no back-pressure: each request yields exactly one sample one cycle later.

Top module: `stfifo_pair`

## Requirements
- R1: Each channel stores up to DEPTH=6 samples of WIDTH=24 bits. `lt_ready`/`rt_ready` is low exactly while that channel holds 6 samples. A beat offered with ready low is discarded, leaves the stored samples unchanged and sets `flag_xrun`. Readiness is judged on the occupancy at the start of the cycle, even if a read happens in the same cycle.
- R2: Left and right samples are stored separately. Each channel returns its samples in the order they were accepted, whether software writes all left samples before the right ones or alternates left and right.
- R3: After reset the first `smp_req` serves the left channel, and each further request toggles the side. One cycle after a request, `smp_valid` is high for one cycle with `smp_right` = 0 for left and 1 for right. `smp_fill` = 0 and `smp_data` = the channel's oldest sample when a sample was taken.
- R4: A right-side request that finds the right FIFO empty returns `smp_data` = 0 with `smp_fill` = 1 and sets `flag_xrun`. The next left-side request then takes no sample: it returns 0 with `smp_fill` = 1 and the left FIFO keeps its head.
- R5: A left-side request that finds the left FIFO empty returns 0 with `smp_fill` = 1 and sets `flag_xrun`. The next right-side request is suppressed in the same way.
- R6: Every suppressed request sets `flag_resync`. A suppressed request never counts as an underrun, even when its side is empty.
- R7: `buf_empty` is high exactly while both FIFOs are empty. It reflects occupancy after the previous clock edge.
- R8: `flag_xrun` and `flag_resync` hold until a pulse on `clr_xrun` or `clr_resync` respectively. A new event in the same cycle as the clear keeps the flag set.
- R9: Synchronous `srst` empties both FIFOs, cancels any pending suppression, returns the side to left, and clears both flags and `smp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| lt_valid | input | 1 | Left sample offered |
| lt_data | input | 24 | Left sample |
| lt_ready | output | 1 | Left FIFO has space |
| rt_valid | input | 1 | Right sample offered |
| rt_data | input | 24 | Right sample |
| rt_ready | output | 1 | Right FIFO has space |
| smp_req | input | 1 | Consumer requests the next sample |
| smp_valid | output | 1 | Sample result present |
| smp_data | output | 24 | Sample, zero when filled |
| smp_right | output | 1 | Result belongs to the right channel |
| smp_fill | output | 1 | Zero-filled result (underrun or suppressed) |
| buf_empty | output | 1 | Both FIFOs empty |
| flag_xrun | output | 1 | Sticky overrun/underrun |
| flag_resync | output | 1 | Sticky resynchronisation |
| clr_xrun | input | 1 | Write-one-to-clear for flag_xrun |
| clr_resync | input | 1 | Write-one-to-clear for flag_resync |

## Verification
The assertions assume that `srst` is applied before the first request and that the inputs are driven to known values at every clock edge. They place no limit on write or request timing: beats offered while not ready are legal and must be dropped. The bench drives inputs only at falling edges and resets before each pattern. It deliberately offers beats to full FIFOs and requests samples from empty ones, so the drop and underrun paths are exercised without going outside these assumptions.

// File: rtl/stfifo_pkg.sv
package stfifo_pkg;
  localparam int unsigned DEF_WIDTH = 24;
  localparam int unsigned DEF_DEPTH = 6;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;
endpackage

// File: rtl/stfifo_chan.sv
module stfifo_chan #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned DEPTH = 6
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic             ovf
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign ovf     = push && full;
  assign head    = mem[rptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (srst)
    count <= CW'(DEPTH));

  assert_full_drop_R1: assert property (@(posedge clk) disable iff (srst)
    (push && full && !pop) |=> (count == CW'(DEPTH)));

  assert_pop_order_R2: assert property (@(posedge clk) disable iff (srst)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/stfifo_seq.sv
module stfifo_seq #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             req,
  input  logic             l_empty,
  input  logic             r_empty,
  input  logic [WIDTH-1:0] l_head,
  input  logic [WIDTH-1:0] r_head,
  output logic             l_pop,
  output logic             r_pop,
  output logic             under,
  output logic             resync,
  output logic             smp_valid,
  output logic [WIDTH-1:0] smp_data,
  output logic             smp_right,
  output logic             smp_fill
);
  import stfifo_pkg::*;

  side_e side;
  logic  blk_l, blk_r;
  logic  blk_cur, emp_cur, take;
  logic  set_blk_l, set_blk_r, clr_blk_l, clr_blk_r;

  always_comb begin
    blk_cur   = (side == SIDE_L) ? blk_l : blk_r;
    emp_cur   = (side == SIDE_L) ? l_empty : r_empty;
    take      = 1'b0;
    under     = 1'b0;
    resync    = 1'b0;
    set_blk_l = 1'b0;
    set_blk_r = 1'b0;
    clr_blk_l = 1'b0;
    clr_blk_r = 1'b0;
    if (req) begin
      if (blk_cur) begin
        resync = 1'b1;
        if (side == SIDE_L) clr_blk_l = 1'b1;
        else                clr_blk_r = 1'b1;
      end else if (emp_cur) begin
        under = 1'b1;
        if (side == SIDE_L) set_blk_r = 1'b1;
        else                set_blk_l = 1'b1;
      end else begin
        take = 1'b1;
      end
    end
    l_pop = take && (side == SIDE_L);
    r_pop = take && (side == SIDE_R);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      side      <= SIDE_L;
      blk_l     <= 1'b0;
      blk_r     <= 1'b0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_right <= 1'b0;
      smp_fill  <= 1'b0;
    end else begin
      if (req) side <= (side == SIDE_L) ? SIDE_R : SIDE_L;
      if (set_blk_l)      blk_l <= 1'b1;
      else if (clr_blk_l) blk_l <= 1'b0;
      if (set_blk_r)      blk_r <= 1'b1;
      else if (clr_blk_r) blk_r <= 1'b0;
      smp_valid <= req;
      smp_right <= (side == SIDE_R);
      smp_fill  <= req && !take;
      smp_data  <= l_pop ? l_head : (r_pop ? r_head : '0);
    end
  end

  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (srst)
    (l_pop |-> !l_empty) and (r_pop |-> !r_empty));

  assert_valid_follows_req_R3: assert property (@(posedge clk) disable iff (srst)
    req |=> smp_valid);

  assert_block_single_R4: assert property (@(posedge clk) disable iff (srst)
    $onehot0({blk_l, blk_r}));

  assert_fill_zero_R5: assert property (@(posedge clk) disable iff (srst)
    (smp_valid && smp_fill) |-> (smp_data == '0));
endmodule

// File: rtl/stfifo_flags.sv
module stfifo_flags (
  input  logic clk,
  input  logic srst,
  input  logic ovf_l,
  input  logic ovf_r,
  input  logic under,
  input  logic resync,
  input  logic clr_xrun,
  input  logic clr_resync,
  output logic flag_xrun,
  output logic flag_resync
);
  logic xrun_ev;
  assign xrun_ev = ovf_l || ovf_r || under;

  always_ff @(posedge clk) begin
    if (srst) begin
      flag_xrun   <= 1'b0;
      flag_resync <= 1'b0;
    end else begin
      if (xrun_ev)       flag_xrun <= 1'b1;
      else if (clr_xrun) flag_xrun <= 1'b0;
      if (resync)          flag_resync <= 1'b1;
      else if (clr_resync) flag_resync <= 1'b0;
    end
  end

  assert_xrun_sticky_R8: assert property (@(posedge clk) disable iff (srst)
    (flag_xrun && !clr_xrun) |=> flag_xrun);

  assert_resync_sticky_R8: assert property (@(posedge clk) disable iff (srst)
    (flag_resync && !clr_resync) |=> flag_resync);

  assert_resync_sets_R6: assert property (@(posedge clk) disable iff (srst)
    resync |=> flag_resync);

  assert_reset_clear_R9: assert property (@(posedge clk)
    srst |=> (!flag_xrun && !flag_resync));
endmodule

// File: rtl/stfifo_pair.sv
module stfifo_pair #(
  parameter int unsigned WIDTH = stfifo_pkg::DEF_WIDTH,
  parameter int unsigned DEPTH = stfifo_pkg::DEF_DEPTH
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             lt_valid,
  input  logic [WIDTH-1:0] lt_data,
  output logic             lt_ready,
  input  logic             rt_valid,
  input  logic [WIDTH-1:0] rt_data,
  output logic             rt_ready,
  input  logic             smp_req,
  output logic             smp_valid,
  output logic [WIDTH-1:0] smp_data,
  output logic             smp_right,
  output logic             smp_fill,
  output logic             buf_empty,
  output logic             flag_xrun,
  output logic             flag_resync,
  input  logic             clr_xrun,
  input  logic             clr_resync
);
  logic [WIDTH-1:0] l_head, r_head;
  logic l_full, r_full, l_empty, r_empty;
  logic l_pop, r_pop, ovf_l, ovf_r, under, resync;

  stfifo_chan #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_left (
    .clk(clk), .srst(srst), .push(lt_valid), .push_data(lt_data),
    .pop(l_pop), .head(l_head), .full(l_full), .empty(l_empty), .ovf(ovf_l)
  );

  stfifo_chan #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_right (
    .clk(clk), .srst(srst), .push(rt_valid), .push_data(rt_data),
    .pop(r_pop), .head(r_head), .full(r_full), .empty(r_empty), .ovf(ovf_r)
  );

  stfifo_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .srst(srst), .req(smp_req),
    .l_empty(l_empty), .r_empty(r_empty), .l_head(l_head), .r_head(r_head),
    .l_pop(l_pop), .r_pop(r_pop), .under(under), .resync(resync),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_right(smp_right),
    .smp_fill(smp_fill)
  );

  stfifo_flags u_flags (
    .clk(clk), .srst(srst), .ovf_l(ovf_l), .ovf_r(ovf_r), .under(under),
    .resync(resync), .clr_xrun(clr_xrun), .clr_resync(clr_resync),
    .flag_xrun(flag_xrun), .flag_resync(flag_resync)
  );

  assign lt_ready  = !l_full;
  assign rt_ready  = !r_full;
  assign buf_empty = l_empty && r_empty;

  assert_empty_both_R7: assert property (@(posedge clk) disable iff (srst)
    buf_empty |-> (lt_ready && rt_ready));

  assert_drop_flags_R1: assert property (@(posedge clk) disable iff (srst)
    ((lt_valid && !lt_ready) || (rt_valid && !rt_ready)) |=> flag_xrun);
endmodule

// File: tb/stfifo_pair_test.sv
module stfifo_pair_test;
  localparam int W = 24;
  localparam int D = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic srst, lt_valid, rt_valid, smp_req, clr_xrun, clr_resync;
  logic [W-1:0] lt_data, rt_data, smp_data;
  logic lt_ready, rt_ready, smp_valid, smp_right, smp_fill;
  logic buf_empty, flag_xrun, flag_resync;

  stfifo_pair uut (
    .clk(clk), .srst(srst),
    .lt_valid(lt_valid), .lt_data(lt_data), .lt_ready(lt_ready),
    .rt_valid(rt_valid), .rt_data(rt_data), .rt_ready(rt_ready),
    .smp_req(smp_req), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_right(smp_right), .smp_fill(smp_fill), .buf_empty(buf_empty),
    .flag_xrun(flag_xrun), .flag_resync(flag_resync),
    .clr_xrun(clr_xrun), .clr_resync(clr_resync)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] ql[$];
  logic [W-1:0] qr[$];
  bit m_blk_l, m_blk_r, m_side, m_xrun, m_rsy;
  int seqno;

  task automatic chk(input string req, input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    srst = 1; lt_valid = 0; rt_valid = 0; smp_req = 0; clr_xrun = 0; clr_resync = 0;
    lt_data = '0; rt_data = '0;
    @(negedge clk);
    @(negedge clk);
    srst = 0;
    ql.delete(); qr.delete();
    m_blk_l = 0; m_blk_r = 0; m_side = 0; m_xrun = 0; m_rsy = 0;
    chk("R9", smp_valid == 0 && flag_xrun == 0 && flag_resync == 0 && buf_empty == 1
              && lt_ready == 1 && rt_ready == 1,
        $sformatf("reset state act v%0b x%0b r%0b e%0b exp v0 x0 r0 e1",
                  smp_valid, flag_xrun, flag_resync, buf_empty));
  endtask

  // one clock: drive at falling edge, evaluate model, check at the next falling edge
  task automatic op(input bit wl, input bit wr, input bit rq, input bit cx, input bit cr);
    bit ev_x, ev_r, e_fill, e_right;
    logic [W-1:0] e_data, dl, dr;
    ev_x = 0; ev_r = 0; e_fill = 0; e_data = '0; e_right = m_side;
    dl = 24'h100000 + W'(seqno);
    dr = 24'h200000 + W'(seqno);
    seqno++;
    lt_valid = wl; rt_valid = wr; smp_req = rq; clr_xrun = cx; clr_resync = cr;
    lt_data = dl; rt_data = dr;
    if (rq) begin
      if (m_side == 0) begin
        if (m_blk_l) begin m_blk_l = 0; ev_r = 1; e_fill = 1; end
        else if (ql.size() == 0) begin m_blk_r = 1; ev_x = 1; e_fill = 1; end
        else e_data = ql.pop_front();
      end else begin
        if (m_blk_r) begin m_blk_r = 0; ev_r = 1; e_fill = 1; end
        else if (qr.size() == 0) begin m_blk_l = 1; ev_x = 1; e_fill = 1; end
        else e_data = qr.pop_front();
      end
      m_side = !m_side;
    end
    if (wl) begin
      if (ql.size() + (rq && e_right == 0 && !e_fill ? 1 : 0) >= D) ev_x = 1;
      else ql.push_back(dl);
    end
    if (wr) begin
      if (qr.size() + (rq && e_right == 1 && !e_fill ? 1 : 0) >= D) ev_x = 1;
      else qr.push_back(dr);
    end
    if (ev_x) m_xrun = 1; else if (cx) m_xrun = 0;
    if (ev_r) m_rsy = 1; else if (cr) m_rsy = 0;
    @(negedge clk);
    lt_valid = 0; rt_valid = 0; smp_req = 0; clr_xrun = 0; clr_resync = 0;
    if (rq)
      chk(e_right ? "R4" : "R5",
          smp_valid == 1 && smp_data == e_data && smp_right == e_right && smp_fill == e_fill,
          $sformatf("sample act v%0b d%h r%0b f%0b exp v1 d%h r%0b f%0b",
                    smp_valid, smp_data, smp_right, smp_fill, e_data, e_right, e_fill));
    else
      chk("R3", smp_valid == 0, $sformatf("idle valid act %0b exp 0", smp_valid));
    chk("R1", lt_ready == (ql.size() < D) && rt_ready == (qr.size() < D),
        $sformatf("ready act %0b%0b exp %0b%0b", lt_ready, rt_ready, ql.size() < D, qr.size() < D));
    chk("R7", buf_empty == (ql.size() == 0 && qr.size() == 0),
        $sformatf("empty act %0b exp %0b", buf_empty, ql.size() == 0 && qr.size() == 0));
    chk("R8", flag_xrun == m_xrun && flag_resync == m_rsy,
        $sformatf("flags act x%0b r%0b exp x%0b r%0b", flag_xrun, flag_resync, m_xrun, m_rsy));
  endtask

  initial begin
    srst = 1; lt_valid = 0; rt_valid = 0; smp_req = 0; clr_xrun = 0; clr_resync = 0;
    lt_data = '0; rt_data = '0; seqno = 0;
    for (int nl = 0; nl <= D + 1; nl++) begin
      for (int nr = 0; nr <= D + 1; nr++) begin
        do_reset();
        if (((nl + nr) % 2) == 0) begin
          // R2 batch order: all left, then all right
          for (int i = 0; i < nl; i++) op(1, 0, 0, 0, 0);
          for (int i = 0; i < nr; i++) op(0, 1, 0, 0, 0);
        end else begin
          // R2 interleaved order
          for (int i = 0; i < D + 1; i++) begin
            if (i < nl) op(1, 0, 0, 0, 0);
            if (i < nr) op(0, 1, 0, 0, 0);
          end
        end
        for (int k = 0; k < 2 * D + 4; k++) op(0, 0, 1, 0, 0);
        // R8 clear racing an event, then plain clear
        op(0, 0, 1, 1, 1);
        op(0, 0, 0, 1, 1);
        // writes concurrent with reads, including drops at full
        for (int k = 0; k < D + 4; k++) op(1, k[0], 1, 0, k == 3);
        for (int k = 0; k < 4; k++) op(1, 1, 0, 0, 0);
      end
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act timeout exp completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule